// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block picks which of eight interrupt lines should be raised to the processor. It works from three inputs: the pending-request bits, the mask bits and its own in-service bits. Priority is circular. A rotation offset names the line that currently has the highest priority, and the remaining lines follow it in increasing line order, wrapping from line 7 to line 0. A pending, unmasked request is presented only when it ranks strictly above every line that is already in service. Two mode flags change which in-service bits take part in that comparison. The special-mask flag drops in-service lines that are masked. The special-nesting flag, on a unit built as the master, drops the cascade line.

The block owns the in-service bits and the rotation offset. An acknowledge strobe puts the current winner into service, or with automatic end-of-interrupt it only rotates the offset. A command port carries end-of-interrupt and priority commands that clear in-service bits and rotate the offset. Capturing requests and decoding the host bus belong to a neighbouring block, which drives the simple ports here.

Top module: `pri_resolver`

## Requirements
- R1: After a synchronous reset, `isr_bits` is 0, `rot_offset` is 0, and `win_valid` and `int_out` are 0.
- R2: Priority level p maps to line (p + `rot_offset`) mod 8, and level 0 ranks highest. The winner is the best-ranked line among the candidate requests.
- R3: A request whose `mask_bits` bit is 1 is never a candidate and never wins.
- R4: A candidate wins only when its level is strictly lower than the level of the best-ranked counted in-service line. When no in-service line is counted, any candidate wins.
- R5: With `spec_mask` = 1, in-service lines whose mask bit is set are not counted.
- R6: With `spec_nest` = 1 and parameter IS_MASTER = 1, in-service line CASC_LINE (default 2) is not counted.
- R7: Command op 1 clears the best-ranked in-service bit, taken from all in-service bits. Op 2 does the same and also sets the offset to that line + 1 mod 8.
- R8: Op 3 clears in-service bit `cmd_line`. Op 4 does the same and also sets the offset to `cmd_line` + 1 mod 8.
- R9: Op 5 sets the offset to `cmd_line` + 1 mod 8. Ops 0, 6 and 7 change nothing.
- R10: With `auto_eoi` = 0, `ack` sets the in-service bit of the current winner, computed from the same cycle's inputs. An `ack` with no winner changes nothing.
- R11: With `auto_eoi` = 1, `ack` leaves the in-service bits unchanged. If `rot_aeoi` = 1 as well, the offset becomes the acknowledged line + 1 mod 8.
- R12: Op 1 or op 2 issued while no in-service bit is set changes neither the in-service bits nor the offset.
- R13: `win_valid`, `win_line` and `int_out` are registered and show the inputs and state one clock edge later. When `cmd_valid` and `ack` are both high in one cycle, the command is applied and the acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_bits | input | 8 | Pending request bits |
| mask_bits | input | 8 | Mask bits, 1 = masked |
| spec_mask | input | 1 | Special-mask mode |
| spec_nest | input | 1 | Special-nesting mode |
| auto_eoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi | input | 1 | Rotate on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R7 to R9) |
| cmd_line | input | 3 | Line field of the command |
| win_valid | output | 1 | Registered: a winner exists |
| win_line | output | 3 | Registered winning line |
| int_out | output | 1 | Registered interrupt output level |
| isr_bits | output | 8 | In-service bits |
| rot_offset | output | 3 | Current rotation offset |

## Verification
Commands and acknowledges change `isr_bits` and `rot_offset` at the clock edge where they are sampled. A winner that depends on that new state therefore appears on `win_valid`, `win_line` and `int_out` one edge later, which is two edges after the command. A change on `req_bits`, `mask_bits` or a mode flag shows on the outputs after one edge. The bench drives inputs on falling edges and reads each result at the falling edge after the edge where it is due. It also checks once that an output still holds its old value before that edge. The sweeps cover every offset, every single in-service line and all 256 request patterns in each mode.

// File: rtl/pri_res_pkg.sv
package pri_res_pkg;
  typedef enum logic [2:0] {
    OP_NOP          = 3'd0,
    OP_EOI_HI       = 3'd1,
    OP_EOI_HI_ROT   = 3'd2,
    OP_EOI_LINE     = 3'd3,
    OP_EOI_LINE_ROT = 3'd4,
    OP_SET_TOP      = 3'd5
  } pri_op_e;
endpackage

// File: rtl/rot_pri_enc.sv
module rot_pri_enc #(
  parameter int N  = 8,
  parameter int OW = 3,
  parameter int LW = 4
) (
  input  logic [N-1:0]  bits,
  input  logic [OW-1:0] offset,
  output logic          found,
  output logic [LW-1:0] level,
  output logic [OW-1:0] line
);
  localparam int SW = OW + 1;

  logic [N-1:0] rot;

  for (genvar p = 0; p < N; p++) begin : g_rot
    logic [SW-1:0] sum;
    always_comb begin
      sum = SW'(p) + {1'b0, offset};
      if (sum >= SW'(N)) sum = sum - SW'(N);
      rot[p] = bits[sum[OW-1:0]];
    end
  end

  always_comb begin
    level = LW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) level = LW'(i);
    end
  end

  assign found = |bits;

  logic [SW-1:0] lsum;
  always_comb begin
    lsum = {1'b0, level[OW-1:0]} + {1'b0, offset};
    if (lsum >= SW'(N)) lsum = lsum - SW'(N);
    line = lsum[OW-1:0];
  end
endmodule

// File: rtl/pri_winner.sv
module pri_winner #(
  parameter int N         = 8,
  parameter int OW        = 3,
  parameter int LW        = 4,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic [N-1:0]  req_bits,
  input  logic [N-1:0]  mask_bits,
  input  logic [N-1:0]  isr_bits,
  input  logic [OW-1:0] offset,
  input  logic          spec_mask,
  input  logic          spec_nest,
  output logic          win_valid_n,
  output logic [OW-1:0] win_line_n
);
  logic [N-1:0]  cand;
  logic [N-1:0]  counted;
  logic [N-1:0]  nest_ign;
  logic          req_found, cur_found;
  logic [LW-1:0] req_lvl, cur_lvl;
  logic [OW-1:0] cur_line;

  if (IS_MASTER) begin : g_master
    assign nest_ign = spec_nest ? (N'(1) << CASC_LINE) : '0;
  end else begin : g_slave
    logic unused_nest;
    assign unused_nest = spec_nest;
    assign nest_ign    = '0;
  end

  assign cand    = req_bits & ~mask_bits;
  assign counted = isr_bits & ~(spec_mask ? mask_bits : '0) & ~nest_ign;

  rot_pri_enc #(.N(N), .OW(OW), .LW(LW)) u_req_enc (
    .bits(cand), .offset(offset), .found(req_found),
    .level(req_lvl), .line(win_line_n)
  );

  rot_pri_enc #(.N(N), .OW(OW), .LW(LW)) u_cur_enc (
    .bits(counted), .offset(offset), .found(cur_found),
    .level(cur_lvl), .line(cur_line)
  );

  logic unused_cur;
  assign unused_cur = cur_found ^ (|cur_line);

  assign win_valid_n = req_found && (req_lvl < cur_lvl);
endmodule

// File: rtl/pri_isr_ctrl.sv
module pri_isr_ctrl
  import pri_res_pkg::*;
#(
  parameter int N  = 8,
  parameter int OW = 3,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [OW-1:0] cmd_line,
  input  logic          ack,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  logic          win_valid_n,
  input  logic [OW-1:0] win_line_n,
  output logic [N-1:0]  isr_q,
  output logic [OW-1:0] off_q
);
  logic          hi_found;
  logic [LW-1:0] hi_lvl;
  logic [OW-1:0] hi_line;

  rot_pri_enc #(.N(N), .OW(OW), .LW(LW)) u_hi_enc (
    .bits(isr_q), .offset(off_q), .found(hi_found),
    .level(hi_lvl), .line(hi_line)
  );

  logic unused_lvl;
  assign unused_lvl = |hi_lvl;

  function automatic logic [OW-1:0] next_line(input logic [OW-1:0] x);
    return (x == OW'(N - 1)) ? '0 : x + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      off_q <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_EOI_HI, OP_EOI_HI_ROT: begin
          if (hi_found) begin
            isr_q[hi_line] <= 1'b0;
            if (cmd_op == OP_EOI_HI_ROT) off_q <= next_line(hi_line);
          end
        end
        OP_EOI_LINE, OP_EOI_LINE_ROT: begin
          isr_q[cmd_line] <= 1'b0;
          if (cmd_op == OP_EOI_LINE_ROT) off_q <= next_line(cmd_line);
        end
        OP_SET_TOP: off_q <= next_line(cmd_line);
        default: ;
      endcase
    end else if (ack && win_valid_n) begin
      if (auto_eoi) begin
        if (rot_aeoi) off_q <= next_line(win_line_n);
      end else begin
        isr_q[win_line_n] <= 1'b1;
      end
    end
  end

  assert_ack_sets_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !cmd_valid && !auto_eoi && win_valid_n) |=> isr_q[$past(win_line_n)]);

  assert_aeoi_keeps_isr_R11: assert property (@(posedge clk) disable iff (rst)
    (ack && !cmd_valid && auto_eoi) |=> (isr_q == $past(isr_q)));

  assert_line_eoi_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_EOI_LINE || cmd_op == OP_EOI_LINE_ROT))
    |=> !isr_q[$past(cmd_line)]);

  assert_empty_eoi_stable_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_EOI_HI || cmd_op == OP_EOI_HI_ROT) && isr_q == '0)
    |=> (isr_q == '0 && $stable(off_q)));
endmodule

// File: rtl/pri_resolver.sv
module pri_resolver #(
  parameter int N         = 8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2,
  localparam int OW       = (N > 1) ? $clog2(N) : 1,
  localparam int LW       = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_bits,
  input  logic [N-1:0]  mask_bits,
  input  logic          spec_mask,
  input  logic          spec_nest,
  input  logic          auto_eoi,
  input  logic          rot_aeoi,
  input  logic          ack,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [OW-1:0] cmd_line,
  output logic          win_valid,
  output logic [OW-1:0] win_line,
  output logic          int_out,
  output logic [N-1:0]  isr_bits,
  output logic [OW-1:0] rot_offset
);
  logic          win_valid_n;
  logic [OW-1:0] win_line_n;
  logic [N-1:0]  isr_q;
  logic [OW-1:0] off_q;

  pri_winner #(.N(N), .OW(OW), .LW(LW), .IS_MASTER(IS_MASTER),
               .CASC_LINE(CASC_LINE)) u_winner (
    .req_bits(req_bits), .mask_bits(mask_bits), .isr_bits(isr_q),
    .offset(off_q), .spec_mask(spec_mask), .spec_nest(spec_nest),
    .win_valid_n(win_valid_n), .win_line_n(win_line_n)
  );

  pri_isr_ctrl #(.N(N), .OW(OW), .LW(LW)) u_isr (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .ack(ack), .auto_eoi(auto_eoi),
    .rot_aeoi(rot_aeoi), .win_valid_n(win_valid_n),
    .win_line_n(win_line_n), .isr_q(isr_q), .off_q(off_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_line  <= '0;
      int_out   <= 1'b0;
    end else begin
      win_valid <= win_valid_n;
      win_line  <= win_valid_n ? win_line_n : '0;
      int_out   <= win_valid_n;
    end
  end

  assign isr_bits   = isr_q;
  assign rot_offset = off_q;

  logic [N-1:0] cand_chk;
  assign cand_chk = req_bits & ~mask_bits;

  assert_winner_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
    win_valid_n |-> cand_chk[win_line_n]);

  assert_int_registered_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(int_out) |-> $past(win_valid_n));
endmodule

// File: tb/test_pri_resolver.sv
`timescale 1ns/1ps
module test_pri_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_bits = '0, mask_bits = '0;
  logic       spec_mask = 0, spec_nest = 0, auto_eoi = 0, rot_aeoi = 0;
  logic       ack = 0, cmd_valid = 0;
  logic [2:0] cmd_op = '0, cmd_line = '0;
  logic       win_valid, int_out;
  logic [2:0] win_line, rot_offset;
  logic [7:0] isr_bits;

  int checks = 0, errors = 0;
  logic [7:0] e_isr = '0;
  int e_off = 0;

  always #2.5 clk = ~clk;

  pri_resolver i_pri_resolver (
    .clk(clk), .rst(rst), .req_bits(req_bits), .mask_bits(mask_bits),
    .spec_mask(spec_mask), .spec_nest(spec_nest), .auto_eoi(auto_eoi),
    .rot_aeoi(rot_aeoi), .ack(ack), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .win_valid(win_valid), .win_line(win_line),
    .int_out(int_out), .isr_bits(isr_bits), .rot_offset(rot_offset)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [7:0] m, input int off);
    for (int p = 0; p < 8; p++) if (m[(p + off) % 8]) return p;
    return 8;
  endfunction

  function automatic int model(input logic [7:0] rq, input logic [7:0] mk,
                               input logic [7:0] is, input int off,
                               input bit smm, input bit sfn);
    int rl, cl;
    logic [7:0] cm;
    rl = lvl_of(rq & ~mk, off);
    if (rl == 8) return -1;
    cm = is;
    if (smm) cm = cm & ~mk;
    if (sfn) cm = cm & ~8'h04;
    cl = lvl_of(cm, off);
    return (rl < cl) ? (rl + off) % 8 : -1;
  endfunction

  task automatic chk_out(input string tag);
    int e;
    e = model(req_bits, mask_bits, e_isr, e_off, spec_mask, spec_nest);
    chk({tag, " valid"}, int'(win_valid), int'(e >= 0));
    chk({tag, " int"}, int'(int_out), int'(e >= 0));
    if (e >= 0) chk({tag, " line"}, int'(win_line), e);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " isr"}, int'(isr_bits), int'(e_isr));
    chk({tag, " offset"}, int'(rot_offset), e_off);
  endtask

  task automatic cmd(input int op, input int ln);
    cmd_valid = 1; cmd_op = 3'(op); cmd_line = 3'(ln);
    tick();
    cmd_valid = 0; cmd_op = '0; cmd_line = '0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    chk("R1 valid", int'(win_valid), 0);
    chk("R1 int", int'(int_out), 0);
    chk_state("R1");

    // R2 R4 R5 R6: sweep mode x offset x single in-service line x requests
    for (int mode = 0; mode < 3; mode++) begin
      for (int o = 0; o < 8; o++) begin
        for (int s = 0; s < 9; s++) begin
          spec_mask = 0; spec_nest = 0; mask_bits = '0; req_bits = '0;
          cmd(5, (o + 7) % 8); e_off = o;       // R9 op 5
          if (s < 8) begin
            req_bits = 8'(1 << s);
            do_ack(); e_isr = 8'(1 << s);       // R10
            req_bits = '0;
          end
          if (mode == 1) begin spec_mask = 1; if (s < 8) mask_bits = 8'(1 << s); end
          if (mode == 2) spec_nest = 1;
          tag = (mode == 0) ? "R2/R4" : (mode == 1) ? "R5" : "R6";
          for (int r = 0; r < 256; r++) begin
            req_bits = 8'(r);
            tick();
            chk_out(tag);
          end
          chk_state(tag);
          spec_mask = 0; spec_nest = 0; mask_bits = '0; req_bits = '0;
          if (s < 8) begin cmd(3, s); e_isr = '0; end  // R8 op 3
        end
      end
    end

    // R3: mask sweep, offset 0, nothing in service
    cmd(5, 7); e_off = 0;
    for (int pat = 0; pat < 2; pat++) begin
      for (int m = 0; m < 256; m++) begin
        req_bits = pat ? 8'h5A : 8'hFF; mask_bits = 8'(m);
        tick();
        chk_out("R3");
      end
    end
    mask_bits = '0; req_bits = '0;

    // R10: acknowledge puts the winner in service; ack without a winner is ignored
    req_bits = 8'h0C; do_ack(); e_isr = 8'h04;
    chk_state("R10 ack line2");
    tick(); chk_out("R10 line3 blocked");
    do_ack(); chk_state("R10 ack no winner");
    req_bits = '0;

    // R7: non-specific EOI variants; build in-service {5,2}
    cmd(3, 2); e_isr = '0;
    req_bits = 8'h20; do_ack(); e_isr = 8'h20;
    req_bits = 8'h04; do_ack(); e_isr = 8'h24;
    req_bits = '0;
    chk_state("R7 setup");
    cmd(1, 0); e_isr = 8'h20; chk_state("R7 eoi best");
    cmd(2, 0); e_isr = 8'h00; e_off = 6; chk_state("R7 eoi best rotate");
    // R12: EOI with nothing in service
    cmd(1, 0); chk_state("R12 eoi empty");
    cmd(2, 3); chk_state("R12 eoi rotate empty");

    // R8: specific EOI with and without rotation
    req_bits = 8'h10; do_ack(); e_isr = 8'h10; req_bits = '0;
    chk_state("R8 setup");
    cmd(4, 4); e_isr = '0; e_off = 5; chk_state("R8 line eoi rotate");
    req_bits = 8'h02; do_ack(); e_isr = 8'h02; req_bits = '0;
    cmd(3, 6); chk_state("R8 other line");
    cmd(3, 1); e_isr = '0; chk_state("R8 line eoi");

    // R9: set top priority, ignored op codes
    cmd(5, 7); e_off = 0; chk_state("R9 set wrap");
    cmd(5, 3); e_off = 4; chk_state("R9 set");
    cmd(0, 2); chk_state("R9 op0");
    cmd(6, 2); chk_state("R9 op6");
    cmd(7, 2); chk_state("R9 op7");

    // R11: automatic end-of-interrupt
    auto_eoi = 1; rot_aeoi = 0;
    req_bits = 8'h40; do_ack(); chk_state("R11 aeoi");
    tick(); chk_out("R11 still pending");
    rot_aeoi = 1; do_ack(); e_off = 7; chk_state("R11 aeoi rotate");
    auto_eoi = 0; rot_aeoi = 0; req_bits = '0;

    // R13: command wins over a same-cycle ack; output one edge late
    req_bits = 8'h02;
    ack = 1; cmd(5, 0); ack = 0; e_off = 1; chk_state("R13 cmd over ack");
    req_bits = '0; tick(); chk_out("R13 idle");
    req_bits = 8'h80;
    #1 chk("R13 before edge", int'(win_valid), 0);
    tick(); chk_out("R13 after edge");
    req_bits = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule